// File: doc/BRIEF.md
# UART FIFO Control Unit

This unit holds the receive and transmit character queues for one UART channel. Each queue stores up to 64 bytes. A single control register, which can only be written, sets how the queues behave. Writing it can turn both queues on or off, empty either queue, pick the DMA signalling mode, and choose a level for each of the two trigger outputs. The receive side is loaded by the serial receiver and read by the host. The transmit side is loaded by the host and read by the serial transmitter.

The receive trigger rises once enough characters are waiting to be read. The transmit trigger rises once enough free room exists to accept more characters. The transmit level counts as an enhanced function, so it only changes while the enhanced-mode input is high. When the queues are turned off, each path keeps just one character, as a plain holding register would.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the following hold: `fifo_en` is 0, `dma_mode` is 0, both counts are 0, both overrun flags are 0, `rx_trig` is 0 and `tx_trig` is 1. Both trigger selections are code 00.
- R2: While `fifo_en` is 1, each queue holds up to 64 bytes and returns them in first-in first-out order. The byte taken by a pop appears on the data output one clock after that pop.
- R3: Control bits [7:6] pick the receive level. Code 00 means 8, 01 means 16, 10 means 56 and 11 means 60. While `fifo_en` is 1, `rx_trig` is 1 exactly when `rx_count` is at or above that level.
- R4: Control bits [5:4] pick the transmit level, counted in free spaces. Code 00 means 8, 01 means 16, 10 means 32 and 11 means 56. While `fifo_en` is 1, `tx_trig` is 1 exactly when 64 minus `tx_count` is at or above that level.
- R5: A control write updates the transmit selection only when `enh_en` is 1. Otherwise that selection keeps its old value.
- R6: A write with bit 2 set empties the transmit queue and clears its overrun flag. A write with bit 1 set does the same for the receive queue. A push in that same cycle is discarded. The other queue and both data outputs are left as they were. The clear bits are not stored.
- R7: Bit 0 turns the queues on. A write that changes the value of bit 0 empties both queues. While `fifo_en` is 0, each queue holds one byte, and both triggers use a level of 1.
- R8: Bit 3 is stored and drives `dma_mode`.
- R9: A push into a full queue is dropped and sets that queue's overrun flag. The flag stays set until that queue is cleared.
- R10: A pop from an empty queue leaves both the count and the data output unchanged.
- R11: A push and a pop in the same cycle on a non-empty queue both take effect and leave the count unchanged. This holds even when the queue is full, and then no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data |
| enh_en | input | 1 | Enhanced-function enable; gates writes to the transmit level |
| rx_push | input | 1 | Store a received character |
| rx_din | input | 8 | Received character |
| rx_pop | input | 1 | Host reads one receive character |
| rx_dout | output | 8 | Last character popped from the receive queue |
| tx_push | input | 1 | Host writes one transmit character |
| tx_din | input | 8 | Transmit character |
| tx_pop | input | 1 | Transmitter takes one character |
| tx_dout | output | 8 | Last character popped from the transmit queue |
| rx_count | output | 7 | Characters held in the receive queue |
| tx_count | output | 7 | Characters held in the transmit queue |
| rx_trig | output | 1 | Receive level reached |
| tx_trig | output | 1 | Transmit free-space level reached |
| rx_overrun | output | 1 | Sticky: a receive push was dropped |
| tx_overrun | output | 1 | Sticky: a transmit push was dropped |
| fifo_en | output | 1 | Queues are enabled |
| dma_mode | output | 1 | Selected DMA signalling mode |

## Verification
Two clashes can happen in a single cycle: a control write that clears a queue, and a push into that same queue.

- **Clear against push.** The bench raises the transmit clear bit and `tx_push` on the same clock edge. It then expects an empty transmit queue, with the receive count left alone.
- **Pop against push.** A push and a pop land on the same edge while the receive queue is full. The bench expects the count to stay at 64, no new overrun, and the scoreboard order to remain intact.

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          enh_en,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_dout,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_din,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_dout,
  output logic [$clog2(DEPTH):0] rx_count,
  output logic [$clog2(DEPTH):0] tx_count,
  output logic          rx_trig,
  output logic          tx_trig,
  output logic          rx_overrun,
  output logic          tx_overrun,
  output logic          fifo_en,
  output logic          dma_mode
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic       en_q, dma_q;
  logic [1:0] rsel_q, tsel_q;

  wire        en_chg = ctl_we && (ctl_wdata[0] != en_q);
  wire  [1:0] clr    = {ctl_we && ctl_wdata[2], ctl_we && ctl_wdata[1]} | {2{en_chg}};
  wire [CW-1:0] cap  = en_q ? CW'(DEPTH) : CW'(1);
  wire  [1:0] push   = {tx_push, rx_push};
  wire  [1:0] pop    = {tx_pop, rx_pop};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      rsel_q <= 2'b00;
      tsel_q <= 2'b00;
    end else if (ctl_we) begin
      en_q   <= ctl_wdata[0];
      dma_q  <= ctl_wdata[3];
      rsel_q <= ctl_wdata[7:6];
      if (enh_en) tsel_q <= ctl_wdata[5:4];
    end

  for (genvar g = 0; g < 2; g++) begin : g_path
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] dout_q;
    logic          ovr_q;
    wire  [DW-1:0] din     = (g == 0) ? rx_din : tx_din;
    wire           do_pop  = pop[g] && (cnt_q != '0);
    wire           do_push = push[g] && ((cnt_q != cap) || do_pop);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp     <= '0;
        rp     <= '0;
        cnt_q  <= '0;
        ovr_q  <= 1'b0;
        dout_q <= '0;
      end else if (clr[g]) begin
        wp    <= '0;
        rp    <= '0;
        cnt_q <= '0;
        ovr_q <= 1'b0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop) begin
          rp     <= rp + 1'b1;
          dout_q <= mem[rp];
        end
        cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        if (push[g] && !do_push) ovr_q <= 1'b1;
      end

    always_ff @(posedge clk)
      if (do_push && !clr[g]) mem[wp] <= din;
  end

  logic [CW-1:0] rlvl, tlvl;
  always_comb begin
    case (rsel_q)
      2'b00:   rlvl = CW'(8);
      2'b01:   rlvl = CW'(16);
      2'b10:   rlvl = CW'(56);
      default: rlvl = CW'(60);
    endcase
    case (tsel_q)
      2'b00:   tlvl = CW'(8);
      2'b01:   tlvl = CW'(16);
      2'b10:   tlvl = CW'(32);
      default: tlvl = CW'(56);
    endcase
    if (!en_q) begin
      rlvl = CW'(1);
      tlvl = CW'(1);
    end
  end

  assign rx_count   = g_path[0].cnt_q;
  assign tx_count   = g_path[1].cnt_q;
  assign rx_dout    = g_path[0].dout_q;
  assign tx_dout    = g_path[1].dout_q;
  assign rx_overrun = g_path[0].ovr_q;
  assign tx_overrun = g_path[1].ovr_q;
  assign rx_trig    = rx_count >= rlvl;
  assign tx_trig    = (cap - tx_count) >= tlvl;
  assign fifo_en    = en_q;
  assign dma_mode   = dma_q;

  // R7
  disabled_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));

  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[1]) |=> (rx_count == '0));

  // R6
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[2]) |=> (tx_count == '0));

  // R5
  tsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !enh_en) |=> $stable(tsel_q));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push && rx_count == '0) |=> ($stable(rx_dout) && rx_count == '0));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !(ctl_we && (ctl_wdata[1] || ctl_wdata[0] != fifo_en))) |=> rx_overrun);

  // R11
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_pop && rx_count != '0 && !ctl_we) |=> $stable(rx_count));
endmodule

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, enh_en = 0;
  logic [7:0] ctl_wdata = 0;
  logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_din = 0, tx_din = 0, rx_dout, tx_dout;
  logic [6:0] rx_count, tx_count;
  logic rx_trig, tx_trig, rx_overrun, tx_overrun, fifo_en, dma_mode;

  always #5 clk = ~clk;

  uart_fifo_ctrl i_uart_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .enh_en(enh_en),
    .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .rx_count(rx_count), .tx_count(tx_count), .rx_trig(rx_trig), .tx_trig(tx_trig),
    .rx_overrun(rx_overrun), .tx_overrun(tx_overrun), .fifo_en(fifo_en), .dma_mode(dma_mode));

  int n_chk = 0, n_fail = 0, seed = 1;
  byte unsigned rxq[$], txq[$];
  bit m_en = 0;
  logic rx_pend = 0, tx_pend = 0;
  logic [7:0] rx_exp = 0, tx_exp = 0, last;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: take expected item on each effective pop, compare after the edge
  always @(posedge clk) begin
    rx_pend <= rx_pop && rxq.size() != 0;
    tx_pend <= tx_pop && txq.size() != 0;
    if (rx_pop && rxq.size() != 0) rx_exp <= rxq.pop_front();
    if (tx_pop && txq.size() != 0) tx_exp <= txq.pop_front();
  end
  always @(negedge clk) begin
    if (rx_pend) chk("R2 rx data order", rx_dout, rx_exp);
    if (tx_pend) chk("R2 tx data order", tx_dout, tx_exp);
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = v;
    if (v[1] || v[0] != m_en) rxq.delete();
    if (v[2] || v[0] != m_en) txq.delete();
    m_en = v[0];
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic push(input int p, input logic [7:0] d, input bit with_pop);
    int cap;
    cap = m_en ? 64 : 1;
    @(negedge clk);
    if (p == 0) begin
      rx_push = 1; rx_din = d; rx_pop = with_pop;
      if (rxq.size() < cap || (with_pop && rxq.size() != 0)) rxq.push_back(d);
    end else begin
      tx_push = 1; tx_din = d; tx_pop = with_pop;
      if (txq.size() < cap || (with_pop && txq.size() != 0)) txq.push_back(d);
    end
    @(negedge clk);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic pop(input int p);
    @(negedge clk);
    if (p == 0) rx_pop = 1; else tx_pop = 1;
    @(negedge clk);
    rx_pop = 0; tx_pop = 0;
  endtask

  task automatic fill(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 5 + 3;
      push(p, 8'(seed), 0);
    end
  endtask

  task automatic drain(input int p, input int n);
    for (int i = 0; i < n; i++) pop(p);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 fifo_en", fifo_en, 0);
    chk("R1 dma_mode", dma_mode, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_trig", rx_trig, 0);
    chk("R1 tx_trig", tx_trig, 1);
    chk("R1 overruns", {rx_overrun, tx_overrun}, 0);

    // R7: disabled, single holding entry
    push(0, 8'hA5, 0);
    chk("R7 rx_count disabled", rx_count, 1);
    chk("R7 rx_trig level 1", rx_trig, 1);
    push(0, 8'h5A, 0);
    chk("R9 rx dropped when holding full", rx_count, 1);
    chk("R9 rx_overrun set", rx_overrun, 1);
    push(1, 8'h33, 0);
    chk("R7 tx_trig no space", tx_trig, 0);
    pop(0);
    pop(1);
    chk("R7 tx_trig space", tx_trig, 1);
    wr(8'h02);
    chk("R6 rx overrun cleared", rx_overrun, 0);
    wr(8'h01);
    chk("R7 fifo_en", fifo_en, 1);

    // R3 receive levels
    fill(0, 7);  chk("R3 rx level 8 below", rx_trig, 0);
    fill(0, 1);  chk("R3 rx level 8 at", rx_trig, 1);
    wr(8'h41);   chk("R3 rx level 16 below", rx_trig, 0);
    fill(0, 8);  chk("R3 rx level 16 at", rx_trig, 1);
    wr(8'h81);
    fill(0, 39); chk("R3 rx level 56 below", rx_trig, 0);
    fill(0, 1);  chk("R3 rx level 56 at", rx_trig, 1);
    wr(8'hC1);   chk("R3 rx level 60 below", rx_trig, 0);
    fill(0, 4);  chk("R3 rx level 60 at", rx_trig, 1);
    fill(0, 4);  chk("R2 rx full count", rx_count, 64);
    chk("R9 no overrun yet", rx_overrun, 0);
    fill(0, 1);
    chk("R9 rx push to full dropped", rx_count, 64);
    chk("R9 rx_overrun", rx_overrun, 1);
    push(0, 8'h7E, 1);
    chk("R11 push+pop at full count", rx_count, 64);
    chk("R9 overrun sticky", rx_overrun, 1);
    drain(0, 64);
    chk("R2 rx drained", rx_count, 0);
    last = rx_dout;
    pop(0);
    chk("R10 empty pop count", rx_count, 0);
    chk("R10 empty pop data", rx_dout, last);
    wr(8'hC3);
    chk("R6 rx overrun cleared by clear", rx_overrun, 0);

    // R5 / R4 transmit levels
    enh_en = 0;
    wr(8'h31);
    fill(1, 56); chk("R5 tx level kept 8 at", tx_trig, 1);
    fill(1, 1);  chk("R5 tx level kept 8 below", tx_trig, 0);
    enh_en = 1;
    wr(8'h11);
    drain(1, 9); chk("R4 tx level 16 at", tx_trig, 1);
    fill(1, 1);  chk("R4 tx level 16 below", tx_trig, 0);
    wr(8'h21);
    drain(1, 17); chk("R4 tx level 32 at", tx_trig, 1);
    fill(1, 1);   chk("R4 tx level 32 below", tx_trig, 0);
    wr(8'h31);
    drain(1, 25); chk("R4 tx level 56 at", tx_trig, 1);
    fill(1, 1);   chk("R4 tx level 56 below", tx_trig, 0);
    enh_en = 0;
    wr(8'h01);
    chk("R5 tx level not rewritten", tx_trig, 0);
    enh_en = 1;

    // R6 clear colliding with push; R11 push+pop not full
    fill(0, 3);
    push(0, 8'h42, 1);
    chk("R11 push+pop count", rx_count, 3);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = 8'h05; tx_push = 1; tx_din = 8'hEE;
    txq.delete();
    @(negedge clk);
    ctl_we = 0; tx_push = 0;
    chk("R6 tx cleared, push lost", tx_count, 0);
    chk("R6 rx untouched", rx_count, 3);
    drain(0, 3);

    // R8
    wr(8'h09); chk("R8 dma_mode 1", dma_mode, 1);
    wr(8'h01); chk("R8 dma_mode 0", dma_mode, 0);

    // R7 disable empties
    fill(0, 2);
    wr(8'h00);
    chk("R7 disable empties rx", rx_count, 0);
    chk("R7 fifo_en off", fifo_en, 0);
    chk("R7 tx_trig level 1", tx_trig, 1);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule